// File: doc/BRIEF.md
# Configurable GPIO port controller

This block runs one 8-pin general-purpose I/O port from three byte-wide registers on a simple register bus. The latch register holds the output values. The direction register picks input or output for each pin. The mode register changes meaning with direction. For an input, a mode bit of 0 gives a floating input and a 1 gives a pulled-up input that takes part in interrupts. For an output, a mode bit of 0 gives a push-pull driver and a 1 gives an open-drain driver. Bit n of each register controls pin n.

The port drives a digital model of each pad: a drive value, an output enable and a pull-up enable. Pin levels pass through a two-flop synchronizer before any logic sees them. On-chip peripherals can take a pin through an override pair, which forces the pin to output and drives the peripheral's value. Every pin set up as an interrupt input is ANDed into one active-low request line for the external interrupt controller. That controller chooses edge or level sensitivity and latches the request.

Top module: `gpio_port`

## Requirements
- R1: Reset (rst_ni low) clears all three registers to 00h. Every pin is then a floating input: pad_oe_o = 00h, pad_pu_o = 00h and irq_n_o = 1.
- R2: The bus maps the latch at offset 0, direction at offset 1 and mode at offset 2. A direction bit of 1 makes pin n an output and a 0 makes it an input. Reading offset 1 or offset 2 returns the stored byte.
- R3: For each pin whose direction bit is 0, a read of offset 0 returns the synchronized pin level. A change on pad_i shows up in that read after two rising clock edges.
- R4: For each pin whose direction bit is 1, a read of offset 0 returns the stored latch bit and not the pin level.
- R5: A write to offset 0 while a pin is an input updates only the latch, and the pin is not driven. The latch value is driven as soon as the direction bit is set to 1.
- R6: A push-pull output (direction 1, mode 0) has pad_oe_o = 1 and pad_o equal to the latch bit.
- R7: An open-drain output (direction 1, mode 1) drives low (pad_oe_o = 1, pad_o = 0) when its latch bit is 0 and releases the pin (pad_oe_o = 0) when its latch bit is 1. pad_o is never 1 in open-drain mode.
- R8: An input with mode bit 1 has pad_pu_o = 1 and is enabled for interrupts. An input with mode bit 0, and any pin that is driven, has pad_pu_o = 0.
- R9: When alt_en_i[n] is 1, pin n is an output regardless of its direction bit. It drives alt_do_i[n], push-pull or open-drain as its mode bit selects. It has no pull-up and no interrupt contribution.
- R10: irq_n_o is the AND of the synchronized levels of all interrupt-enabled pins, so one such pin held low pulls it low. irq_n_o is 1 when no pin is enabled, and pins that are not enabled have no effect on it.
- R11: A read of offset 3 returns 00h. A write to offset 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 2 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from bus_addr_i |
| pad_i | input | 8 | Pin levels from the pads |
| pad_o | output | 8 | Drive value per pin, 0 when not driven |
| pad_oe_o | output | 8 | Output enable per pin |
| pad_pu_o | output | 8 | Pull-up enable per pin |
| alt_en_i | input | 8 | Peripheral override per pin |
| alt_do_i | input | 8 | Peripheral drive value per pin |
| irq_n_o | output | 1 | Group interrupt request, active low |

## Verification
The bench writes the latch while the pins are inputs, then checks that nothing is driven and that reads still return the pins. A design that drove the latch early, or read it back instead of the pins, fails there. It mixes outputs and inputs in one byte and reads offset 0, which catches a read that picks latch or pin for the whole byte instead of per bit. It sets open-drain outputs with latch bits of 1 and checks that they release the pin rather than drive high. It holds one interrupt-enabled pin low and checks that the others are masked. It then takes that pin with a peripheral override, which must remove the pin from the AND and turn its pull-up off. It also writes the unmapped offset and checks that no register was hit through a partial address decode.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LATCH = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_MODE  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_sel_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [NPINS-1:0]     bus_wdata_i,
  input  logic [NPINS-1:0]     pin_lvl_i,
  output logic [NPINS-1:0]     bus_rdata_o,
  output logic [NPINS-1:0]     latch_o,
  output logic [NPINS-1:0]     dir_o,
  output logic [NPINS-1:0]     mode_o
);
  logic [NPINS-1:0] latch_q, dir_q, mode_q;
  logic             wr;

  assign wr = bus_sel_i & bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      dir_q   <= '0;
      mode_q  <= '0;
    end else if (wr) begin
      case (reg_sel_e'(bus_addr_i))
        SEL_LATCH: latch_q <= bus_wdata_i;
        SEL_DIR:   dir_q   <= bus_wdata_i;
        SEL_MODE:  mode_q  <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  // per bit: outputs read the latch, inputs read the pin
  always_comb begin
    case (reg_sel_e'(bus_addr_i))
      SEL_LATCH: bus_rdata_o = (dir_q & latch_q) | (~dir_q & pin_lvl_i);
      SEL_DIR:   bus_rdata_o = dir_q;
      SEL_MODE:  bus_rdata_o = mode_q;
      default:   bus_rdata_o = '0;
    endcase
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;
  assign mode_o  = mode_q;

  assert_rsvd_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == SEL_NONE) |=> ($stable(latch_q) && $stable(dir_q) && $stable(mode_q)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pad_i,
  output logic [NPINS-1:0] lvl_o
);
  logic [NPINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= pad_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign lvl_o = stage_q[STAGES-1];

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_sync_delay_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (STAGES == 2 && age_q == 2'd3) |-> (lvl_o == $past(pad_i, 2)));
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int unsigned NPINS = 8
) (
  input  logic [NPINS-1:0] latch_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] mode_i,
  input  logic [NPINS-1:0] alt_en_i,
  input  logic [NPINS-1:0] alt_do_i,
  output logic [NPINS-1:0] pad_o,
  output logic [NPINS-1:0] pad_oe_o,
  output logic [NPINS-1:0] pad_pu_o,
  output logic [NPINS-1:0] irq_en_o
);
  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic drv, val, odrain;
    assign drv    = dir_i[n] | alt_en_i[n];
    assign val    = alt_en_i[n] ? alt_do_i[n] : latch_i[n];
    assign odrain = mode_i[n];
    always_comb begin
      pad_oe_o[n] = 1'b0;
      pad_o[n]    = 1'b0;
      if (drv) begin
        if (odrain) begin
          pad_oe_o[n] = ~val;
        end else begin
          pad_oe_o[n] = 1'b1;
          pad_o[n]    = val;
        end
      end
    end
    assign pad_pu_o[n] = ~drv & mode_i[n];
    assign irq_en_o[n] = ~drv & mode_i[n];
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned NPINS = 8
) (
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] en_i,
  output logic             irq_n_o
);
  assign irq_n_o = &(lvl_i | ~en_i);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  input  logic [NPINS-1:0]  pad_i,
  output logic [NPINS-1:0]  pad_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pad_pu_o,
  input  logic [NPINS-1:0]  alt_en_i,
  input  logic [NPINS-1:0]  alt_do_i,
  output logic              irq_n_o
);
  logic [NPINS-1:0] lvl, latch, dir, mode, irq_en;

  gpio_sync #(.NPINS(NPINS), .STAGES(2)) i_sync (
    .clk_i, .rst_ni, .pad_i, .lvl_o(lvl)
  );

  gpio_regs #(.NPINS(NPINS)) i_regs (
    .clk_i, .rst_ni, .bus_sel_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .pin_lvl_i(lvl), .bus_rdata_o, .latch_o(latch), .dir_o(dir), .mode_o(mode)
  );

  gpio_pin_ctrl #(.NPINS(NPINS)) i_ctrl (
    .latch_i(latch), .dir_i(dir), .mode_i(mode), .alt_en_i, .alt_do_i,
    .pad_o, .pad_oe_o, .pad_pu_o, .irq_en_o(irq_en)
  );

  gpio_irq #(.NPINS(NPINS)) i_irq (
    .lvl_i(lvl), .en_i(irq_en), .irq_n_o
  );

  assert_no_pull_on_output_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & dir) == '0);

  assert_od_never_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_o & mode) == '0);

  assert_irq_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_n_o |-> ((pad_pu_o & ~lvl) != '0));

  assert_alt_drives_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((alt_en_i & ~mode) & ~pad_oe_o) == '0);
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [1:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0, bus_rdata_o;
  logic [7:0] pad_i = '0, pad_o, pad_oe_o, pad_pu_o;
  logic [7:0] alt_en_i = '0, alt_do_i = '0;
  logic       irq_n_o;

  always #5 clk_i = ~clk_i;

  gpio_port #(.NPINS(8)) i_gpio_port (.*);

  typedef enum int {OBS_RD, OBS_OUT, OBS_OE, OBS_PU, OBS_IRQ} obs_e;
  typedef struct { obs_e kind; logic [7:0] exp; string tag; } item_t;

  item_t q[$];
  int    checks = 0, errors = 0;
  bit    mon_go = 1'b0, done = 1'b0;

  // monitor: pops and compares, sampling 2 ns after the edge
  initial forever begin
    @(posedge clk_i);
    #2;
    while (mon_go && q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        OBS_RD:  act = bus_rdata_o;
        OBS_OUT: act = pad_o;
        OBS_OE:  act = pad_oe_o;
        OBS_PU:  act = pad_pu_o;
        default: act = {7'd0, irq_n_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %02h expected %02h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_obs(obs_e k, logic [7:0] e, string tag);
    @(negedge clk_i);
    q.push_back('{k, e, tag});
    mon_go = 1'b1;
    @(negedge clk_i);
    mon_go = 1'b0;
  endtask

  task automatic expect_rd(logic [1:0] a, logic [7:0] e, string tag);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    q.push_back('{OBS_RD, e, tag});
    mon_go = 1'b1;
    @(negedge clk_i);
    mon_go = 1'b0; bus_sel_i = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic set_pads(logic [7:0] v);
    @(negedge clk_i);
    pad_i = v;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 during reset
    expect_obs(OBS_OE, 8'h00, "R1 oe in reset");
    rst_ni = 1'b1;
    expect_obs(OBS_PU, 8'h00, "R1 pu");
    expect_obs(OBS_IRQ, 8'h01, "R1 irq idle");
    expect_rd(2'd1, 8'h00, "R1 dir reset");
    expect_rd(2'd2, 8'h00, "R1 mode reset");
    expect_rd(2'd0, 8'h00, "R1 latch read");
    // R3 synchronized input read
    set_pads(8'hA5);
    expect_rd(2'd0, 8'hA5, "R3 pin read");
    // R5 write latch while inputs
    wr(2'd0, 8'h3C);
    expect_obs(OBS_OE, 8'h00, "R5 not driven");
    expect_rd(2'd0, 8'hA5, "R5 read still pins");
    // R2 R6 push-pull low nibble
    wr(2'd1, 8'h0F);
    expect_rd(2'd1, 8'h0F, "R2 dir readback");
    expect_obs(OBS_OE, 8'h0F, "R6 oe");
    expect_obs(OBS_OUT, 8'h0C, "R5 R6 latch driven");
    expect_rd(2'd0, 8'hAC, "R4 mixed read");
    // R7 open-drain
    wr(2'd2, 8'h0F);
    expect_obs(OBS_OE, 8'h03, "R7 od oe");
    expect_obs(OBS_OUT, 8'h00, "R7 od never high");
    // R8 R10 pull-up interrupt inputs
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hF0);
    expect_rd(2'd2, 8'hF0, "R2 mode readback");
    expect_obs(OBS_PU, 8'hF0, "R8 pullups");
    expect_obs(OBS_OE, 8'h00, "R8 inputs undriven");
    expect_obs(OBS_IRQ, 8'h00, "R10 A5 masks");
    set_pads(8'hF0);
    expect_obs(OBS_IRQ, 8'h01, "R10 low nibble ignored");
    set_pads(8'h7F);
    expect_obs(OBS_IRQ, 8'h00, "R10 pin7 low");
    // R9 alternate function
    @(negedge clk_i);
    alt_en_i = 8'h01; alt_do_i = 8'h01;
    expect_obs(OBS_OE, 8'h01, "R9 alt forces output");
    expect_obs(OBS_OUT, 8'h01, "R9 alt value");
    @(negedge clk_i);
    alt_en_i = 8'h80; alt_do_i = 8'h00;
    expect_obs(OBS_OE, 8'h80, "R9 alt od low");
    expect_obs(OBS_PU, 8'h70, "R9 alt no pullup");
    expect_obs(OBS_IRQ, 8'h01, "R9 R10 alt pin excluded");
    @(negedge clk_i);
    alt_en_i = 8'h00;
    // R11 unmapped offset
    wr(2'd3, 8'hFF);
    expect_rd(2'd3, 8'h00, "R11 rsvd read");
    expect_rd(2'd1, 8'h00, "R11 dir untouched");
    expect_rd(2'd2, 8'hF0, "R11 mode untouched");
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h00);
    expect_rd(2'd0, 8'h3C, "R4 R11 latch untouched");
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule